// File: doc/BRIEF.md
# Debug Port Password Authentication Gate

This block sits between an external debug requester and the on-chip debug register interface. It keeps that interface closed until the requester proves knowledge of a password. A submitted password is captured and handed to an outside keyed-hash engine over a request/done handshake. The returned digest is then checked against an expected digest. The check takes a fixed number of cycles and always covers every digest bit, so its duration does not depend on where a mismatch sits.

After a match the gate opens and passes debug reads and writes through to the target. On the edge that opens the gate, it zeroes a local secret key register. A one-time fuse input shuts the gate regardless of any password. A de-authenticate input closes an open session. Repeated failures lead to a lockout that only a reset ends. The captured password and digest are wiped once every comparison finishes.

Top module: `dbg_auth_gate`

## Requirements
- R1: While reset is asserted and right after it, the gate is closed: accessGrant, authPass, authFail, lockedOut and hashReq are 0, and hashMsg and keyOut are 0.
- R2: tgtRdEn and tgtWrEn follow dbgRdEn and dbgWrEn only while accessGrant is 1 and are 0 otherwise. dbgRdata equals tgtRdata while accessGrant is 1 and is 0 otherwise.
- R3: In the closed (not locked-out) state, pwValid captures pwData. From the next cycle hashMsg shows the password and hashReq is 1, until the edge that samples hashDone high. A pwValid in any other state is ignored.
- R4: The digest is captured on the hashDone edge. After that edge the comparison spends exactly CMP_CYCLES = DG_W/CHUNK_W clock edges (4 by default) against expDigest. The result pulse is high during the cycle that follows the last of those edges, for a match and for a mismatch alike.
- R5: A match gives a single-cycle authPass, opens the gate (accessGrant 1 from that cycle) and clears the consecutive failure count.
- R6: A mismatch gives a single-cycle authFail and returns the gate to the closed state.
- R7: When MAX_FAIL (3) mismatches occur in a row, lockedOut rises in the authFail cycle. From then on, passwords and the fuse have no effect, and only reset clears it.
- R8: keyWe loads keyWdata into keyOut on the next edge in every state except open. The key reads 0 from the cycle the gate opens, and keyWe is ignored while the gate is open.
- R9: hashMsg reads 0 in the cycle after every comparison completes, whatever the result.
- R10: deauth drops accessGrant combinationally in the same cycle, and the gate is closed from the next edge.
- R11: fuseDisable forces accessGrant, tgtRdEn and tgtWrEn low in the same cycle. Outside lockout, each edge with fuseDisable set closes the gate, abandons any hash or compare in progress (clearing hashMsg) and ignores pwValid. An abandoned attempt does not count as a failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fuseDisable | input | 1 | Permanent debug disable |
| pwValid | input | 1 | Password submit strobe |
| pwData | input | PW_W | Submitted password |
| hashReq | output | 1 | Request to the keyed-hash engine |
| hashMsg | output | PW_W | Captured password sent to the hash engine |
| hashDone | input | 1 | Hash engine completion |
| hashDigest | input | DG_W | Digest returned by the hash engine |
| expDigest | input | DG_W | Stored expected digest |
| deauth | input | 1 | Close an open session |
| keyWe | input | 1 | Secret key write enable |
| keyWdata | input | KEY_W | Secret key write data |
| keyOut | output | KEY_W | Secret key value |
| dbgRdEn | input | 1 | Debug read request |
| dbgWrEn | input | 1 | Debug write request |
| dbgAddr | input | AW | Debug register address |
| dbgWdata | input | DW | Debug write data |
| dbgRdata | output | DW | Gated debug read data |
| tgtRdEn | output | 1 | Gated read enable to the target |
| tgtWrEn | output | 1 | Gated write enable to the target |
| tgtAddr | output | AW | Address to the target |
| tgtWdata | output | DW | Write data to the target |
| tgtRdata | input | DW | Read data from the target |
| accessGrant | output | 1 | Gate is open |
| authPass | output | 1 | One-cycle match pulse |
| authFail | output | 1 | One-cycle mismatch pulse |
| lockedOut | output | 1 | Lockout after repeated failures |

## Verification
The gating outputs (accessGrant, tgtRdEn, tgtWrEn, dbgRdata) respond in the same cycle as deauth, fuseDisable and the debug requests. Everything else changes one edge after its cause: hashMsg and hashReq after pwValid, and the pass or fail pulse CMP_CYCLES edges after the hashDone edge. The bench's reference model follows the same rule. It advances its registered state on each rising edge from the inputs driven at the preceding falling edge, and works out the same-cycle gating from the current inputs. Every output is compared two time units after each falling edge, once all inputs and combinational paths have settled.

// File: rtl/dag_pkg.sv
package dag_pkg;

  typedef enum logic [2:0] {
    ST_CLOSED  = 3'd0,
    ST_HASH    = 3'd1,
    ST_CMP     = 3'd2,
    ST_OPEN    = 3'd3,
    ST_LOCKOUT = 3'd4
  } dagState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capPw;    // capture submitted password
    logic capDg;    // capture returned digest, clear accumulator
    logic cmpEn;    // fold current chunk into mismatch accumulator
    logic wipe;     // clear password, digest and accumulator
    logic zeroKey;  // zeroize secret key
    logic keyLock;  // block key writes
  } dagStrobe_t;

endpackage

// File: rtl/dag_ctrl.sv
module dag_ctrl
  import dag_pkg::*;
#(
  parameter int NCHUNK   = 4,
  parameter int MAX_FAIL = 3,
  parameter int IDX_W    = 2,
  parameter int FAIL_W   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fuseDisable,
  input  logic             pwValid,
  input  logic             hashDone,
  input  logic             deauth,
  input  logic             cmpMismatch,
  output dagStrobe_t       stb,
  output logic [IDX_W-1:0] cmpIdx,
  output logic             hashReq,
  output logic             accessGrant,
  output logic             authPass,
  output logic             authFail,
  output logic             lockedOut
);

  dagState_e         state, stateNxt;
  logic [FAIL_W-1:0] failCnt;
  logic              abort;
  logic              lastChunk;
  logic              cmpDone;
  logic              passNxt;
  logic              failNxt;

  assign abort     = fuseDisable && (state != ST_LOCKOUT);
  assign lastChunk = (cmpIdx == IDX_W'(NCHUNK - 1));
  assign cmpDone   = !abort && (state == ST_CMP) && lastChunk;
  assign passNxt   = cmpDone && !cmpMismatch;
  assign failNxt   = cmpDone && cmpMismatch;

  always_comb begin
    stb      = '0;
    stateNxt = state;
    if (abort) begin
      stb.wipe = 1'b1;
      stateNxt = ST_CLOSED;
    end else begin
      unique case (state)
        ST_CLOSED: begin
          if (pwValid) begin
            stb.capPw = 1'b1;
            stateNxt  = ST_HASH;
          end
        end
        ST_HASH: begin
          if (hashDone) begin
            stb.capDg = 1'b1;
            stateNxt  = ST_CMP;
          end
        end
        ST_CMP: begin
          stb.cmpEn = 1'b1;
          if (lastChunk) begin
            stb.wipe = 1'b1;
            if (!cmpMismatch) begin
              stb.zeroKey = 1'b1;
              stateNxt    = ST_OPEN;
            end else if (failCnt == FAIL_W'(MAX_FAIL - 1)) begin
              stateNxt = ST_LOCKOUT;
            end else begin
              stateNxt = ST_CLOSED;
            end
          end
        end
        ST_OPEN: begin
          if (deauth) stateNxt = ST_CLOSED;
        end
        ST_LOCKOUT: stateNxt = ST_LOCKOUT;
        default:    stateNxt = ST_CLOSED;
      endcase
    end
    stb.keyLock = (state == ST_OPEN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_CLOSED;
      cmpIdx   <= '0;
      failCnt  <= '0;
      authPass <= 1'b0;
      authFail <= 1'b0;
    end else begin
      state    <= stateNxt;
      authPass <= passNxt;
      authFail <= failNxt;
      if (abort || stb.capDg || (stb.cmpEn && lastChunk)) begin
        cmpIdx <= '0;
      end else if (stb.cmpEn) begin
        cmpIdx <= cmpIdx + 1'b1;
      end
      if (passNxt) begin
        failCnt <= '0;
      end else if (failNxt) begin
        failCnt <= failCnt + 1'b1;
      end
    end
  end

  assign hashReq     = (state == ST_HASH);
  assign lockedOut   = (state == ST_LOCKOUT);
  assign accessGrant = (state == ST_OPEN) && !deauth && !fuseDisable;

endmodule

// File: rtl/dag_dpath.sv
module dag_dpath
  import dag_pkg::*;
#(
  parameter int PW_W    = 32,
  parameter int DG_W    = 32,
  parameter int CHUNK_W = 8,
  parameter int NCHUNK  = 4,
  parameter int IDX_W   = 2,
  parameter int KEY_W   = 32,
  parameter int AW      = 8,
  parameter int DW      = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dagStrobe_t       stb,
  input  logic [IDX_W-1:0] cmpIdx,
  input  logic             accessGrant,
  input  logic [PW_W-1:0]  pwData,
  input  logic [DG_W-1:0]  hashDigest,
  input  logic [DG_W-1:0]  expDigest,
  input  logic             keyWe,
  input  logic [KEY_W-1:0] keyWdata,
  input  logic             dbgRdEn,
  input  logic             dbgWrEn,
  input  logic [AW-1:0]    dbgAddr,
  input  logic [DW-1:0]    dbgWdata,
  input  logic [DW-1:0]    tgtRdata,
  output logic [PW_W-1:0]  hashMsg,
  output logic             cmpMismatch,
  output logic [KEY_W-1:0] keyOut,
  output logic             tgtRdEn,
  output logic             tgtWrEn,
  output logic [AW-1:0]    tgtAddr,
  output logic [DW-1:0]    tgtWdata,
  output logic [DW-1:0]    dbgRdata
);

  logic [PW_W-1:0]   pwReg;
  logic [DG_W-1:0]   dgReg;
  logic [KEY_W-1:0]  keyReg;
  logic              acc;
  logic [NCHUNK-1:0] chunkNe;

  // One inequality flag per digest chunk; one is folded in per cycle
  for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
    assign chunkNe[g] = |(dgReg[g*CHUNK_W +: CHUNK_W] ^ expDigest[g*CHUNK_W +: CHUNK_W]);
  end

  assign cmpMismatch = acc | chunkNe[cmpIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwReg  <= '0;
      dgReg  <= '0;
      acc    <= 1'b0;
      keyReg <= '0;
    end else begin
      if (stb.wipe) begin
        pwReg <= '0;
        dgReg <= '0;
        acc   <= 1'b0;
      end else begin
        if (stb.capPw) pwReg <= pwData;
        if (stb.capDg) begin
          dgReg <= hashDigest;
          acc   <= 1'b0;
        end else if (stb.cmpEn) begin
          acc <= cmpMismatch;
        end
      end
      if (stb.zeroKey) begin
        keyReg <= '0;
      end else if (keyWe && !stb.keyLock) begin
        keyReg <= keyWdata;
      end
    end
  end

  assign hashMsg  = pwReg;
  assign keyOut   = keyReg;
  assign tgtRdEn  = dbgRdEn && accessGrant;
  assign tgtWrEn  = dbgWrEn && accessGrant;
  assign tgtAddr  = dbgAddr;
  assign tgtWdata = dbgWdata;
  assign dbgRdata = accessGrant ? tgtRdata : '0;

endmodule

// File: rtl/dbg_auth_gate.sv
module dbg_auth_gate
  import dag_pkg::*;
#(
  parameter int PW_W     = 32,
  parameter int DG_W     = 32,
  parameter int CHUNK_W  = 8,
  parameter int MAX_FAIL = 3,
  parameter int KEY_W    = 32,
  parameter int AW       = 8,
  parameter int DW       = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fuseDisable,
  input  logic             pwValid,
  input  logic [PW_W-1:0]  pwData,
  output logic             hashReq,
  output logic [PW_W-1:0]  hashMsg,
  input  logic             hashDone,
  input  logic [DG_W-1:0]  hashDigest,
  input  logic [DG_W-1:0]  expDigest,
  input  logic             deauth,
  input  logic             keyWe,
  input  logic [KEY_W-1:0] keyWdata,
  output logic [KEY_W-1:0] keyOut,
  input  logic             dbgRdEn,
  input  logic             dbgWrEn,
  input  logic [AW-1:0]    dbgAddr,
  input  logic [DW-1:0]    dbgWdata,
  output logic [DW-1:0]    dbgRdata,
  output logic             tgtRdEn,
  output logic             tgtWrEn,
  output logic [AW-1:0]    tgtAddr,
  output logic [DW-1:0]    tgtWdata,
  input  logic [DW-1:0]    tgtRdata,
  output logic             accessGrant,
  output logic             authPass,
  output logic             authFail,
  output logic             lockedOut
);

  // DG_W must be a multiple of CHUNK_W
  localparam int NCHUNK = DG_W / CHUNK_W;
  localparam int IDX_W  = (NCHUNK > 1) ? $clog2(NCHUNK) : 1;
  localparam int FAIL_W = $clog2(MAX_FAIL + 1);

  dagStrobe_t       stb;
  logic [IDX_W-1:0] cmpIdx;
  logic             cmpMismatch;

  dag_ctrl #(
    .NCHUNK(NCHUNK), .MAX_FAIL(MAX_FAIL), .IDX_W(IDX_W), .FAIL_W(FAIL_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .fuseDisable(fuseDisable), .pwValid(pwValid),
    .hashDone(hashDone), .deauth(deauth), .cmpMismatch(cmpMismatch),
    .stb(stb), .cmpIdx(cmpIdx), .hashReq(hashReq), .accessGrant(accessGrant),
    .authPass(authPass), .authFail(authFail), .lockedOut(lockedOut)
  );

  dag_dpath #(
    .PW_W(PW_W), .DG_W(DG_W), .CHUNK_W(CHUNK_W), .NCHUNK(NCHUNK),
    .IDX_W(IDX_W), .KEY_W(KEY_W), .AW(AW), .DW(DW)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .cmpIdx(cmpIdx), .accessGrant(accessGrant),
    .pwData(pwData), .hashDigest(hashDigest), .expDigest(expDigest),
    .keyWe(keyWe), .keyWdata(keyWdata), .dbgRdEn(dbgRdEn), .dbgWrEn(dbgWrEn),
    .dbgAddr(dbgAddr), .dbgWdata(dbgWdata), .tgtRdata(tgtRdata),
    .hashMsg(hashMsg), .cmpMismatch(cmpMismatch), .keyOut(keyOut),
    .tgtRdEn(tgtRdEn), .tgtWrEn(tgtWrEn), .tgtAddr(tgtAddr),
    .tgtWdata(tgtWdata), .dbgRdata(dbgRdata)
  );

endmodule

// File: rtl/dag_checker.sv
module dag_checker #(
  parameter int PW_W  = 32,
  parameter int KEY_W = 32,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             fuseDisable,
  input logic             deauth,
  input logic             hashReq,
  input logic             hashDone,
  input logic [PW_W-1:0]  hashMsg,
  input logic [KEY_W-1:0] keyOut,
  input logic [DW-1:0]    dbgRdata,
  input logic             tgtRdEn,
  input logic             tgtWrEn,
  input logic             accessGrant,
  input logic             authPass,
  input logic             authFail,
  input logic             lockedOut
);

  AST_CLOSED_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !accessGrant |-> (dbgRdata == '0 && !tgtWrEn && !tgtRdEn)); // R2

  AST_HASH_REQ_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (hashReq && hashDone) |=> !hashReq); // R3

  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(authPass && authFail)); // R4

  AST_PASS_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    authPass |=> !authPass); // R5

  AST_GRANT_NEEDS_PASS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(accessGrant) |-> authPass); // R5

  AST_FAIL_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    authFail |=> !authFail); // R6

  AST_LOCKOUT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    lockedOut |=> lockedOut); // R7

  AST_LOCKOUT_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    lockedOut |-> !accessGrant); // R7

  AST_KEY_ZERO_ON_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    authPass |-> keyOut == '0); // R8

  AST_MSG_WIPED: assert property (@(posedge clk) disable iff (!rstN)
    (authPass || authFail) |-> hashMsg == '0); // R9

  AST_DEAUTH_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    deauth |=> !accessGrant); // R10

  AST_FUSE_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    fuseDisable |-> (!accessGrant && !tgtWrEn && !tgtRdEn)); // R11

endmodule

bind dbg_auth_gate dag_checker #(.PW_W(PW_W), .KEY_W(KEY_W), .DW(DW)) i_dagChecker (
  .clk(clk), .rstN(rstN), .fuseDisable(fuseDisable), .deauth(deauth),
  .hashReq(hashReq), .hashDone(hashDone), .hashMsg(hashMsg), .keyOut(keyOut),
  .dbgRdata(dbgRdata), .tgtRdEn(tgtRdEn), .tgtWrEn(tgtWrEn),
  .accessGrant(accessGrant), .authPass(authPass), .authFail(authFail),
  .lockedOut(lockedOut)
);

// File: tb/test_dbg_auth_gate.sv
`timescale 1ns/1ps
module test_dbg_auth_gate;

  localparam int PW_W = 32, DG_W = 32, CHUNK_W = 8, MAXF = 3;
  localparam int KEY_W = 32, AW = 8, DW = 32;
  localparam int NCH = DG_W / CHUNK_W;
  localparam logic [31:0] GOOD = 32'h1234_ABCD;
  localparam logic [31:0] BAD1 = GOOD ^ 32'h0000_0001;
  localparam logic [31:0] BAD2 = GOOD ^ 32'h0001_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fuseDisable = 1'b0, pwValid = 1'b0, hashDone = 1'b0, deauth = 1'b0;
  logic keyWe = 1'b0, dbgRdEn = 1'b0, dbgWrEn = 1'b0;
  logic [PW_W-1:0] pwData = '0;
  logic [KEY_W-1:0] keyWdata = '0;
  logic [AW-1:0] dbgAddr = '0;
  logic [DW-1:0] dbgWdata = '0;
  logic [DG_W-1:0] hashDigest, expDigest;
  logic [DW-1:0] tgtRdata;
  logic hashReq, tgtRdEn, tgtWrEn, accessGrant, authPass, authFail, lockedOut;
  logic [PW_W-1:0] hashMsg;
  logic [KEY_W-1:0] keyOut;
  logic [DW-1:0] dbgRdata, tgtWdata;
  logic [AW-1:0] tgtAddr;

  int nChecks = 0, nFails = 0, hashLat = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [31:0] hashFn(input logic [31:0] m);
    return {m[26:0], m[31:27]} ^ 32'h9E37_79B9;
  endfunction

  assign hashDigest = hashFn(hashMsg);
  assign expDigest  = hashFn(GOOD);
  assign tgtRdata   = {~tgtAddr, tgtAddr, 16'hBEEF};

  dbg_auth_gate i_dbg_auth_gate (
    .clk(clk), .rstN(rstN), .fuseDisable(fuseDisable), .pwValid(pwValid),
    .pwData(pwData), .hashReq(hashReq), .hashMsg(hashMsg), .hashDone(hashDone),
    .hashDigest(hashDigest), .expDigest(expDigest), .deauth(deauth),
    .keyWe(keyWe), .keyWdata(keyWdata), .keyOut(keyOut), .dbgRdEn(dbgRdEn),
    .dbgWrEn(dbgWrEn), .dbgAddr(dbgAddr), .dbgWdata(dbgWdata), .dbgRdata(dbgRdata),
    .tgtRdEn(tgtRdEn), .tgtWrEn(tgtWrEn), .tgtAddr(tgtAddr), .tgtWdata(tgtWdata),
    .tgtRdata(tgtRdata), .accessGrant(accessGrant), .authPass(authPass),
    .authFail(authFail), .lockedOut(lockedOut)
  );

  // Hash engine stand-in: done three falling edges into a request
  always @(negedge clk) begin
    if (!hashReq) begin
      hashLat  = 0;
      hashDone = 1'b0;
    end else if (hashDone) begin
      hashDone = 1'b0;
      hashLat  = 0;
    end else begin
      hashLat++;
      hashDone = (hashLat >= 3);
    end
  end

  // Reference model: 0 closed, 1 hashing, 2 comparing, 3 open, 4 lockout
  int mSt, mFails, mCnt;
  logic [31:0] mPw, mDg, mKey;
  bit mPass, mFail;

  always @(posedge clk or negedge rstN) begin
    int st;
    bit pN, fN;
    if (!rstN) begin
      mSt = 0; mFails = 0; mCnt = 0; mPw = '0; mDg = '0; mKey = '0;
      mPass = 1'b0; mFail = 1'b0;
    end else begin
      st = mSt; pN = 1'b0; fN = 1'b0;
      if (keyWe && mSt != 3) mKey = keyWdata;
      if (fuseDisable && mSt != 4) begin
        st = 0; mPw = '0; mDg = '0; mCnt = 0;
      end else begin
        case (mSt)
          0: if (pwValid) begin mPw = pwData; st = 1; end
          1: if (hashDone) begin mDg = hashDigest; mCnt = 0; st = 2; end
          2: begin
            if (mCnt == NCH - 1) begin
              if (mDg == expDigest) begin
                st = 3; pN = 1'b1; mFails = 0; mKey = '0;
              end else begin
                mFails++; fN = 1'b1; st = (mFails >= MAXF) ? 4 : 0;
              end
              mPw = '0; mDg = '0; mCnt = 0;
            end else mCnt++;
          end
          3: if (deauth) st = 0;
          default: ;
        endcase
      end
      mSt = st; mPass = pN; mFail = fN;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s at %0t: actual %h expected %h", req, what, $time, act, exp);
    end
  endtask

  // Compare every output with the model once per cycle, away from the edges
  always @(negedge clk) begin
    bit g;
    #2;
    if (!finished) begin
      g = (mSt == 3) && !deauth && !fuseDisable;
      chk("R5", "accessGrant", 64'(accessGrant), 64'(g));
      chk("R2", "tgtRdEn", 64'(tgtRdEn), 64'(dbgRdEn && g));
      chk("R2", "tgtWrEn", 64'(tgtWrEn), 64'(dbgWrEn && g));
      chk("R2", "dbgRdata", 64'(dbgRdata), g ? 64'({~dbgAddr, dbgAddr, 16'hBEEF}) : 64'd0);
      chk("R3", "hashReq", 64'(hashReq), 64'(mSt == 1));
      chk("R9", "hashMsg", 64'(hashMsg), 64'(mPw));
      chk("R4", "authPass", 64'(authPass), 64'(mPass));
      chk("R6", "authFail", 64'(authFail), 64'(mFail));
      chk("R7", "lockedOut", 64'(lockedOut), 64'(mSt == 4));
      chk("R8", "keyOut", 64'(keyOut), 64'(mKey));
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dbgRdEn  = 1'b1;
      dbgWrEn  = i[0];
      dbgAddr  = dbgAddr + 8'd7;
      dbgWdata = {dbgAddr, 24'h00C0DE};
      pwValid  = 1'b0;
      keyWe    = 1'b0;
      deauth   = 1'b0;
    end
  endtask

  task automatic submit(input logic [31:0] pw);
    @(negedge clk);
    pwValid = 1'b1; pwData = pw;
    idle(14);
  endtask

  task automatic writeKey(input logic [31:0] k);
    @(negedge clk);
    keyWe = 1'b1; keyWdata = k;
    idle(2);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1'b1;
      nFails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    idle(3);
    #2;
    chk("R1", "grant in reset", 64'(accessGrant), 64'd0);
    chk("R1", "hashMsg in reset", 64'(hashMsg), 64'd0);
    @(negedge clk); rstN = 1'b1;
    idle(2);
    #2;
    chk("R1", "closed after reset", 64'({accessGrant, lockedOut, hashReq}), 64'd0);

    writeKey(32'hCAFE_F00D);
    submit(BAD1);                 // R6 first failure
    submit(GOOD);                 // R5 open, R8 key zeroed
    writeKey(32'h1111_2222);      // R8 ignored while open
    idle(4);
    @(negedge clk); deauth = 1'b1;
    #2;
    chk("R10", "grant drops with deauth", 64'(accessGrant), 64'd0);
    idle(3);

    submit(BAD2);                 // R4 mismatch in a high chunk
    submit(BAD1);
    submit(GOOD);                 // count cleared
    @(negedge clk); fuseDisable = 1'b1;
    #2;
    chk("R11", "grant drops with fuse", 64'(accessGrant), 64'd0);
    @(negedge clk); pwValid = 1'b1; pwData = GOOD;
    @(negedge clk); pwValid = 1'b0;
    #2;
    chk("R11", "pwValid ignored under fuse", 64'(hashReq), 64'd0);
    idle(3);
    @(negedge clk); fuseDisable = 1'b0;

    @(negedge clk); pwValid = 1'b1; pwData = GOOD;
    idle(2);
    fuseDisable = 1'b1;           // abort during hashing
    idle(3);
    #2;
    chk("R11", "hash abandoned", 64'({hashReq, hashMsg}), 64'd0);
    @(negedge clk); fuseDisable = 1'b0;
    idle(2);

    writeKey(32'h5EC2_E7AA);
    submit(BAD1);
    submit(BAD2);
    submit(BAD1);                 // R7 third failure
    #2;
    chk("R7", "lockout reached", 64'(lockedOut), 64'd1);
    submit(GOOD);                 // R7 ignored
    @(negedge clk); fuseDisable = 1'b1;
    idle(2);
    @(negedge clk); fuseDisable = 1'b0;
    #2;
    chk("R7", "lockout holds", 64'(lockedOut), 64'd1);
    @(negedge clk); rstN = 1'b0;
    idle(2);
    @(negedge clk); rstN = 1'b1;
    #2;
    chk("R1", "reset clears lockout", 64'(lockedOut), 64'd0);
    submit(GOOD);
    #2;
    chk("R5", "open after reset", 64'(accessGrant), 64'd1);
    idle(4);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule